// File: doc/BRIEF.md
# MDIO Management Master

This block drives PHY management transactions on the two-wire MDC/MDIO bus. A host presents the access type (read or write, short or extended framing), the PHY address, a 5-bit register number or device address, a 16-bit register address for extended accesses and the write data, then pulses `start`. The block derives MDC from the system clock, shifts each frame out MSB first, and controls the shared data pin through separate output, output-enable and input signals. It pulses `done` at the end and leaves any read result on `rdata`.

An extended (Clause 45) access is two back-to-back frames. The first frame loads the register address. The second frame performs the read or the write. On reads, the master checks the turnaround bit the PHY returns. If the PHY does not pull it low and the PHY is not listed in a per-address ignore mask, the master flushes the bus with 32 extra clocks and returns all ones.

Top module: `mdio_master`

## Requirements
- R1: While reset is held and after it is released, `mdc` is low, `mdio_oe` is low, and `busy`, `done` and `rdata` are zero.
- R2: Every frame opens with 32 preamble bits of value 1, all driven by the master (`mdio_oe` high).
- R3: After the preamble, the start field is 0,1 for a Clause 22 frame and 0,0 for a Clause 45 frame. The opcode that follows is 10 (C22 read), 01 (C22 write), 00 (C45 address), 01 (C45 write) or 11 (C45 read). All bits are sent left to right as written.
- R4: When `op_sel` is high at start, `alt_rd_op` and `alt_wr_op` replace the C22 read and write opcodes. When `op_sel` is low, the defaults from R3 apply.
- R5: After the opcode, the 5-bit PHY address and then a 5-bit field are sent MSB first. The field carries the register number in C22 frames and the device address in C45 frames.
- R6: Write and address frames then drive the turnaround as 1 then 0, followed by 16 data bits MSB first. The master then releases MDIO for one final clock.
- R7: A C45 access sends an address frame whose data is `c45_reg`. It then sends a second frame with the read or write opcode, and that frame's 5-bit field carries the device address.
- R8: In a read frame, MDIO is released after the 5-bit field. One turnaround bit is sampled. If it is 0, 16 data bits are sampled MSB first, followed by one idle clock, and the result appears on `rdata` with `done`.
- R9: If the sampled turnaround bit is 1 and bit `phy_addr` of `ignore_ta` is 0, the master runs 32 more released clocks and then reports `rdata` = 0xFFFF.
- R10: If bit `phy_addr` of `ignore_ta` is 1, a turnaround bit of 1 does not abort the read. The 16 data bits are taken as in R8.
- R11: For driven bits, MDC stays low for HALF_CYC system clocks and then high for HALF_CYC clocks. For sampled bits, the high phase lasts RD_HIGH_CYC clocks. MDIO output and enable change only while MDC is low. The input is sampled at the clock edge that returns MDC low.
- R12: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse during which `busy` is low. A `start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction when idle |
| is_c45 | input | 1 | 1 selects Clause 45 framing |
| is_read | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | PHY address |
| reg_dev | input | 5 | Register number (C22) or device address (C45) |
| c45_reg | input | 16 | Register address for C45 accesses |
| wdata | input | 16 | Write data |
| op_sel | input | 1 | Use the alternate C22 opcodes |
| alt_rd_op | input | 2 | Alternate C22 read opcode |
| alt_wr_op | input | 2 | Alternate C22 write opcode |
| ignore_ta | input | 32 | Per-PHY-address turnaround ignore mask |
| mdio_i | input | 1 | MDIO pin input |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| rdata | output | 16 | Last read result |
| done | output | 1 | Transaction finished pulse |
| busy | output | 1 | Transaction in progress |

## Verification
Four properties are checked on every cycle. The pin drive and enable hold still whenever MDC is high. MDC and the output enable stay low while idle. `done` lasts one cycle and never coincides with `busy`. A start that arrives mid-transaction leaves the latched request untouched. The bit content of each frame, the phase lengths, the split of C45 accesses into two frames, and the read outcomes (good turnaround, aborted with all ones, or forced through by the mask) can only be shown by the bench scenarios. The bench compares every cycle against a reference model that plays the PHY side.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CYC    = 13,
  parameter int RD_HIGH_CYC = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_c45,
  input  logic        is_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_dev,
  input  logic [15:0] c45_reg,
  input  logic [15:0] wdata,
  input  logic        op_sel,
  input  logic [1:0]  alt_rd_op,
  input  logic [1:0]  alt_wr_op,
  input  logic [31:0] ignore_ta,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rdata,
  output logic        done,
  output logic        busy
);
  localparam int MAXC = (HALF_CYC > RD_HIGH_CYC) ? HALF_CYC : RD_HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          c45_l, rd_l, ign_l, second, ta_bad, ph;
  logic [4:0]    phy_l, fld_l;
  logic [15:0]   reg_l, wd_l, shreg;
  logic [1:0]    rop_l, wop_l, op;
  logic [6:0]    idx;
  logic [CW-1:0] cnt;

  wire addr_fr = c45_l & ~second;
  wire rd_fr   = rd_l & ~addr_fr;

  always_comb begin
    if (c45_l) op = addr_fr ? 2'b00 : (rd_l ? 2'b11 : 2'b01);
    else       op = rd_l ? rop_l : wop_l;
  end

  wire [15:0]   dat  = addr_fr ? reg_l : wd_l;
  wire [63:0]   hdr  = {32'hFFFF_FFFF, 1'b0, ~c45_l, op, phy_l, fld_l, 2'b10, dat};
  wire          drv  = (idx < 7'd46) || (!rd_fr && idx < 7'd64);
  wire [6:0]    last = rd_fr ? (ta_bad ? 7'd78 : 7'd63) : 7'd64;
  wire [CW-1:0] lim  = (ph && !drv) ? CW'(RD_HIGH_CYC - 1) : CW'(HALF_CYC - 1);
  wire          ph_end = (cnt == lim);

  assign mdio_oe = busy & drv;
  assign mdio_o  = mdio_oe & hdr[~idx[5:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; mdc <= 1'b0; done <= 1'b0; rdata <= '0;
      c45_l <= 1'b0; rd_l <= 1'b0; ign_l <= 1'b0; second <= 1'b0;
      ta_bad <= 1'b0; ph <= 1'b0; idx <= '0; cnt <= '0;
      phy_l <= '0; fld_l <= '0; reg_l <= '0; wd_l <= '0; shreg <= '0;
      rop_l <= 2'b10; wop_l <= 2'b01;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          c45_l  <= is_c45;
          rd_l   <= is_read;
          ign_l  <= ignore_ta[phy_addr];
          phy_l  <= phy_addr;
          fld_l  <= reg_dev;
          reg_l  <= c45_reg;
          wd_l   <= wdata;
          rop_l  <= op_sel ? alt_rd_op : 2'b10;
          wop_l  <= op_sel ? alt_wr_op : 2'b01;
          second <= 1'b0;
          ta_bad <= 1'b0;
          ph     <= 1'b0;
          idx    <= '0;
          cnt    <= '0;
          mdc    <= 1'b0;
        end
      end else if (!ph_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!ph) begin
          ph  <= 1'b1;
          mdc <= 1'b1;
        end else begin
          ph  <= 1'b0;
          mdc <= 1'b0;
          if (rd_fr) begin
            if (idx == 7'd46 && mdio_i && !ign_l) ta_bad <= 1'b1;
            if (idx >= 7'd47 && idx <= 7'd62) shreg <= {shreg[14:0], mdio_i};
          end
          if (idx == last) begin
            if (addr_fr) begin
              second <= 1'b1;
              idx    <= '0;
            end else begin
              busy <= 1'b0;
              done <= 1'b1;
              if (rd_l) rdata <= ta_bad ? 16'hFFFF : shreg;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R11
  pin_hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(phy_l) && $stable(fld_l) && $stable(wd_l)));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 13;
  localparam int RDHI = 18;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_c45 = 1'b0, is_read = 1'b0;
  logic [4:0] phy_addr = '0, reg_dev = '0;
  logic [15:0] c45_reg = '0, wdata = '0;
  logic op_sel = 1'b0;
  logic [1:0] alt_rd_op = '0, alt_wr_op = '0;
  logic [31:0] ignore_ta = '0;
  logic mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe, done, busy;
  logic [15:0] rdata;

  always #10 clk = ~clk;

  mdio_master #(.HALF_CYC(HALF), .RD_HIGH_CYC(RDHI)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .start(start), .is_c45(is_c45), .is_read(is_read),
    .phy_addr(phy_addr), .reg_dev(reg_dev), .c45_reg(c45_reg), .wdata(wdata),
    .op_sel(op_sel), .alt_rd_op(alt_rd_op), .alt_wr_op(alt_wr_op),
    .ignore_ta(ignore_ta), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rdata(rdata), .done(done), .busy(busy));

  typedef struct { bit k; bit oe; bit o; bit mi; string tag; } ent_t;
  ent_t q[$];
  int checks = 0, errors = 0;
  logic [15:0] exp_rd = '0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_bit(bit drv, bit val, bit mi, string tag);
    for (int i = 0; i < HALF; i++) q.push_back('{1'b0, drv, drv & val, mi, tag});
    for (int i = 0; i < (drv ? HALF : RDHI); i++) q.push_back('{1'b1, drv, drv & val, mi, tag});
  endtask

  task automatic push_hdr(bit c45, bit [1:0] op, bit [4:0] phy, bit [4:0] fld, string optag);
    for (int i = 0; i < 32; i++) push_bit(1, 1, 1, "R2");
    push_bit(1, 0, 1, "R3");
    push_bit(1, !c45, 1, "R3");
    push_bit(1, op[1], 1, optag);
    push_bit(1, op[0], 1, optag);
    for (int i = 4; i >= 0; i--) push_bit(1, phy[i], 1, "R5");
    for (int i = 4; i >= 0; i--) push_bit(1, fld[i], 1, c45 ? "R7" : "R5");
  endtask

  task automatic push_wr(bit [15:0] d, string dtag);
    push_bit(1, 1, 1, "R6");
    push_bit(1, 0, 1, "R6");
    for (int i = 15; i >= 0; i--) push_bit(1, d[i], 1, dtag);
    push_bit(0, 0, 1, "R6");
  endtask

  task automatic push_rd(bit ta, bit [15:0] resp, bit ign);
    push_bit(0, 0, ta, "R8");
    if (ta && !ign) begin
      for (int i = 0; i < 32; i++) push_bit(0, 0, 1, "R9");
      exp_rd = 16'hFFFF;
    end else begin
      for (int i = 15; i >= 0; i--) push_bit(0, 0, resp[i], ign ? "R10" : "R8");
      push_bit(0, 0, 1, "R8");
      exp_rd = resp;
    end
  endtask

  task automatic run(bit c45, bit rd, bit [4:0] phy, bit [4:0] fld, bit [15:0] r45,
                     bit [15:0] wd, bit ovr, bit [1:0] ard, bit [1:0] awr,
                     bit ta, bit [15:0] resp, bit [31:0] mask, bit poke);
    bit [1:0] op;
    logic [15:0] prev_rd;
    int n;
    prev_rd = rdata;
    @(negedge clk);
    is_c45 = c45; is_read = rd; phy_addr = phy; reg_dev = fld; c45_reg = r45;
    wdata = wd; op_sel = ovr; alt_rd_op = ard; alt_wr_op = awr; ignore_ta = mask;
    start = 1'b1;
    q.delete();
    if (c45) begin
      push_hdr(1, 2'b00, phy, fld, "R3");
      push_wr(r45, "R7");
      push_hdr(1, rd ? 2'b11 : 2'b01, phy, fld, "R3");
    end else begin
      op = rd ? (ovr ? ard : 2'b10) : (ovr ? awr : 2'b01);
      push_hdr(0, op, phy, fld, ovr ? "R4" : "R3");
    end
    if (rd) push_rd(ta, resp, mask[phy]);
    else    push_wr(wd, "R6");
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (q.size() > 0) begin
      ent_t e;
      e = q.pop_front();
      mdio_i = e.mi;
      chk("R11", "mdc", mdc, e.k);
      chk(e.tag, "mdio_oe", mdio_oe, e.oe);
      if (e.oe) chk(e.tag, "mdio_o", mdio_o, e.o);
      chk("R12", "busy", busy, 1);
      chk("R12", "done early", done, 0);
      if (poke && n == 200) begin
        start = 1'b1; phy_addr = ~phy; reg_dev = ~fld; wdata = ~wd;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    mdio_i = 1'b1;
    chk("R12", "done", done, 1);
    chk("R12", "busy at done", busy, 0);
    chk("R11", "mdc at done", mdc, 0);
    chk("R1", "mdio_oe at done", mdio_oe, 0);
    if (rd) chk(ta && !mask[phy] ? "R9" : (mask[phy] ? "R10" : "R8"), "rdata", rdata, exp_rd);
    else    chk("R6", "rdata after write", rdata, prev_rd);
    @(negedge clk);
    chk("R12", "done pulse", done, 0);
    chk("R12", "busy after", busy, 0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "mdc in reset", mdc, 0);
    chk("R1", "oe in reset", mdio_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mdc", mdc, 0);
    chk("R1", "mdio_oe", mdio_oe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "rdata", rdata, 0);
    // R6 R3 R5: C22 write
    run(0, 0, 5'h11, 5'h0A, 16'h0, 16'hA5C3, 0, 2'b00, 2'b00, 0, 16'h0, 32'h0, 0);
    // R8: C22 read, good turnaround
    run(0, 1, 5'h03, 5'h01, 16'h0, 16'h0, 0, 2'b00, 2'b00, 0, 16'h1234, 32'h0, 0);
    // R4: alternate opcodes
    run(0, 1, 5'h1F, 5'h10, 16'h0, 16'h0, 1, 2'b11, 2'b00, 0, 16'h8001, 32'h0, 0);
    run(0, 0, 5'h00, 5'h1F, 16'h0, 16'h7E81, 1, 2'b11, 2'b00, 0, 16'h0, 32'h0, 0);
    // R7: C45 write and read
    run(1, 0, 5'h01, 5'h1E, 16'hBEEF, 16'h0F0F, 0, 2'b00, 2'b00, 0, 16'h0, 32'h0, 0);
    run(1, 1, 5'h15, 5'h03, 16'h4C2D, 16'h0, 0, 2'b00, 2'b00, 0, 16'hCAFE, 32'h0, 0);
    // R9: bad turnaround, mask clear
    run(0, 1, 5'h07, 5'h02, 16'h0, 16'h0, 0, 2'b00, 2'b00, 1, 16'h1111, 32'h0000_0040, 0);
    // R10: bad turnaround, mask bit set
    run(0, 1, 5'h07, 5'h02, 16'h0, 16'h0, 0, 2'b00, 2'b00, 1, 16'h5A5A, 32'h0000_0080, 0);
    // R9: C45 read with bad turnaround
    run(1, 1, 5'h09, 5'h07, 16'h0102, 16'h0, 0, 2'b00, 2'b00, 1, 16'h0, 32'h0, 0);
    // R12: start while busy ignored
    run(0, 0, 5'h0C, 5'h05, 16'h0, 16'h3C96, 0, 2'b00, 2'b00, 0, 16'h0, 32'h0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule